// File: doc/BRIEF.md
# Three-Bank Selectable Clock Divider

This block turns one fast source clock into three banks of divided clocks. Bank A has two outputs and a 2-bit ratio select. Bank B has seven outputs and bank C has one. Banks B and C share a ratio table, but each has its own 3-bit select. A bypass control feeds the dividers from a reference clock in place of the fast clock. The reference is either a crystal clock or an external clock, picked by a select pin. That same reference is also passed through, gated, on two reference outputs.

An active-low master reset holds every divider in reset and forces the bank outputs low. The divide ratios and the bypass choice are captured only while reset is held, so changing a ratio never produces a runt pulse. After release, a two-flop synchronizer in the source domain starts all three dividers. Every output of one bank comes from a single divider, so the outputs of a bank have no skew against each other. A disabled output is driven low, and its enable flag reads zero.

All control pins are plain static levels. The block has no data stream, so it has no valid/ready interface and no back-pressure.

Top module: `mbank_clkdiv`

## Requirements
- R1: Bank A select codes 0, 1, 2, 3 divide the source by 20, 16, 10 and 8. Each output is high for half the ratio in source periods and low for the other half.
- R2: The bank B and bank C select codes 0 to 7 divide the source by 60, 40, 30, 20, 16, 15, 12 and 10 respectively.
- R3: Each bank's ratio comes only from its own select, so banks set to different codes run at their own rates at the same time.
- R4: While rst_n is low, every bank output is low and en_a and en_bc are 0. After rst_n goes high, the dividers restart from the start of a cycle.
- R5: With bypass at 1, the dividers count edges of the chosen reference clock. With bypass at 0, they count edges of vco_clk. A bypass change takes effect only through a reset.
- R6: ref_pick at 0 chooses xtal_clk and ref_pick at 1 chooses ext_ref_clk. The choice applies both to the reference outputs and to the bypass source.
- R7: With oe_ref at 0, both ref_out bits are low and en_ref is 0. With oe_ref at 1, both bits follow the chosen reference.
- R8: oe_a at 0 holds both bank A outputs low and sets en_a to 0. oe_bc at 0 holds all bank B outputs and the bank C output low and sets en_bc to 0. The other bank keeps running in both cases.
- R9: The divide-by-15 ratio gives a high time and a low time of 7.5 source periods each. Every even ratio gives an exact half-and-half duty.
- R10: A select change made while the dividers run does not alter the running ratio. The new ratio applies after the next reset.
- R11: All outputs of one bank carry the same level at every instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast source clock |
| xtal_clk | input | 1 | Crystal reference clock |
| ext_ref_clk | input | 1 | External reference clock |
| rst_n | input | 1 | Active-low master reset of the dividers |
| ref_pick | input | 1 | Reference choice: 0 crystal, 1 external |
| bypass | input | 1 | 1: dividers run from the reference |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 3 | Bank B ratio code |
| sel_c | input | 3 | Bank C ratio code |
| oe_a | input | 1 | Bank A output enable |
| oe_bc | input | 1 | Bank B and C output enable |
| oe_ref | input | 1 | Reference pass-through enable |
| clk_a | output | NUM_A | Bank A clocks |
| clk_b | output | NUM_B | Bank B clocks |
| clk_c | output | 1 | Bank C clock |
| ref_out | output | NUM_REF | Gated reference outputs |
| en_a | output | 1 | Bank A enabled flag |
| en_bc | output | 1 | Banks B and C enabled flag |
| en_ref | output | 1 | Reference outputs enabled flag |

## Verification
The enables and the reference gating are combinational, so their effect is checked half a source cycle after the stimulus. A new ratio appears only after reset release. The release passes through two synchronizer flops, and the first high phase starts on the next source edge. An odd ratio adds half a source cycle to that. The scoreboard therefore waits out the reset recovery, discards the first pulse, and times the second whole pulse by its edges. It compares high and low times against the ratio multiplied by the period of whichever source is in use.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
  localparam int RW       = 6;
  localparam int SEL_A_W  = 2;
  localparam int SEL_BC_W = 3;

  function automatic logic [RW-1:0] ratio_a_f(input logic [SEL_A_W-1:0] s);
    case (s)
      2'd0:    return RW'(20);
      2'd1:    return RW'(16);
      2'd2:    return RW'(10);
      default: return RW'(8);
    endcase
  endfunction

  function automatic logic [RW-1:0] ratio_bc_f(input logic [SEL_BC_W-1:0] s);
    case (s)
      3'd0:    return RW'(60);
      3'd1:    return RW'(40);
      3'd2:    return RW'(30);
      3'd3:    return RW'(20);
      3'd4:    return RW'(16);
      3'd5:    return RW'(15);
      3'd6:    return RW'(12);
      default: return RW'(10);
    endcase
  endfunction
endpackage

// File: rtl/mbank_srcsel.sv
module mbank_srcsel (
  input  logic vco_clk,
  input  logic xtal_clk,
  input  logic ext_ref_clk,
  input  logic ref_pick,
  input  logic use_ref,
  output logic ref_clk,
  output logic src_clk
);
  // reference choice feeds both the pass-through and the bypass path
  assign ref_clk = ref_pick ? ext_ref_clk : xtal_clk;
  assign src_clk = use_ref ? ref_clk : vco_clk;
endmodule

// File: rtl/mbank_rsync.sv
module mbank_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sh;

  // assert at once, release after STAGES source edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign run = sh[STAGES-1];
endmodule

// File: rtl/mbank_div.sv
module mbank_div #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          run,
  input  logic [CW-1:0] ratio,
  output logic          clk_out
);
  logic [CW-1:0] cnt, cnt_nx, half;
  logic [CW:0]   ratio_p1;
  logic          hi_q, lo_q;

  // high phase length: ceil(ratio/2) rising edges
  assign ratio_p1 = {1'b0, ratio} + (CW+1)'(1);
  assign half     = ratio_p1[CW:1];

  // reset value all-ones wraps to 0 on the first running edge
  assign cnt_nx = (cnt >= ratio - CW'(1)) ? '0 : cnt + CW'(1);

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      cnt  <= '1;
      hi_q <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      hi_q <= (cnt_nx < half);
    end
  end

  // half-cycle delayed copy trims the odd-ratio high phase by half a period
  always_ff @(negedge clk or negedge run) begin
    if (!run) lo_q <= 1'b0;
    else      lo_q <= hi_q;
  end

  assign clk_out = ratio[0] ? (hi_q & lo_q) : hi_q;
endmodule

// File: rtl/mbank_clkdiv.sv
module mbank_clkdiv
  import mbank_pkg::*;
#(
  parameter int NUM_A   = 2,
  parameter int NUM_B   = 7,
  parameter int NUM_REF = 2
) (
  input  logic                vco_clk,
  input  logic                xtal_clk,
  input  logic                ext_ref_clk,
  input  logic                rst_n,
  input  logic                ref_pick,
  input  logic                bypass,
  input  logic [SEL_A_W-1:0]  sel_a,
  input  logic [SEL_BC_W-1:0] sel_b,
  input  logic [SEL_BC_W-1:0] sel_c,
  input  logic                oe_a,
  input  logic                oe_bc,
  input  logic                oe_ref,
  output logic [NUM_A-1:0]    clk_a,
  output logic [NUM_B-1:0]    clk_b,
  output logic                clk_c,
  output logic [NUM_REF-1:0]  ref_out,
  output logic                en_a,
  output logic                en_bc,
  output logic                en_ref
);
  localparam int NBANK = 3;

  logic          ref_clk, src_clk, run, byp_q;
  logic [RW-1:0] ratio_a, ratio_b, ratio_c;
  logic [RW-1:0] ratio_v [NBANK];
  logic [NBANK-1:0] div_o;

  // bypass choice captured only while master reset is held
  always_ff @(posedge vco_clk) begin
    if (!rst_n) byp_q <= bypass;
  end

  mbank_srcsel u_src (
    .vco_clk     (vco_clk),
    .xtal_clk    (xtal_clk),
    .ext_ref_clk (ext_ref_clk),
    .ref_pick    (ref_pick),
    .use_ref     (byp_q),
    .ref_clk     (ref_clk),
    .src_clk     (src_clk)
  );

  mbank_rsync #(.STAGES(2)) u_rsync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .run   (run)
  );

  // ratios load only while the dividers are held
  always_ff @(posedge src_clk) begin
    if (!run) begin
      ratio_a <= ratio_a_f(sel_a);
      ratio_b <= ratio_bc_f(sel_b);
      ratio_c <= ratio_bc_f(sel_c);
    end
  end

  assign ratio_v[0] = ratio_a;
  assign ratio_v[1] = ratio_b;
  assign ratio_v[2] = ratio_c;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    mbank_div #(.CW(RW)) u_div (
      .clk     (src_clk),
      .run     (run),
      .ratio   (ratio_v[g]),
      .clk_out (div_o[g])
    );
  end

  assign en_a   = oe_a & rst_n;
  assign en_bc  = oe_bc & rst_n;
  assign en_ref = oe_ref;

  // one divider per bank fans out to all outputs of that bank
  assign clk_a   = {NUM_A{div_o[0] & en_a}};
  assign clk_b   = {NUM_B{div_o[1] & en_bc}};
  assign clk_c   = div_o[2] & en_bc;
  assign ref_out = {NUM_REF{ref_clk & oe_ref}};
endmodule

// File: rtl/mbank_clkdiv_chk.sv
module mbank_clkdiv_chk
  import mbank_pkg::*;
#(
  parameter int NUM_A   = 2,
  parameter int NUM_B   = 7,
  parameter int NUM_REF = 2
) (
  input logic               vco_clk,
  input logic               src_clk,
  input logic               rst_n,
  input logic               run,
  input logic               byp_q,
  input logic               oe_a,
  input logic               oe_bc,
  input logic               oe_ref,
  input logic               en_a,
  input logic               en_bc,
  input logic               en_ref,
  input logic [NUM_A-1:0]   clk_a,
  input logic [NUM_B-1:0]   clk_b,
  input logic               clk_c,
  input logic [NUM_REF-1:0] ref_out,
  input logic [RW-1:0]      ratio_a,
  input logic [RW-1:0]      ratio_b,
  input logic [RW-1:0]      ratio_c
);
  always_ff @(negedge vco_clk) begin
    if (rst_n === 1'b0) begin
      // R4
      r4_reset_low_chk: assert (clk_a == '0 && clk_b == '0 && !clk_c && !en_a && !en_bc);
    end
    if (oe_ref === 1'b0) begin
      // R7
      r7_ref_off_chk: assert (ref_out == '0 && !en_ref);
    end
    if (oe_a === 1'b0) begin
      // R8
      r8_bank_a_off_chk: assert (clk_a == '0);
    end
    if (oe_bc === 1'b0) begin
      // R8
      r8_bank_bc_off_chk: assert (clk_b == '0 && !clk_c);
    end
  end

  // R10
  r10_ratio_hold_chk: assert property (@(posedge src_clk) disable iff (!run)
    $past(run) |-> ($stable(ratio_a) && $stable(ratio_b) && $stable(ratio_c)));

  // R5
  r5_bypass_hold_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(byp_q));
endmodule

bind mbank_clkdiv mbank_clkdiv_chk #(
  .NUM_A(NUM_A), .NUM_B(NUM_B), .NUM_REF(NUM_REF)
) u_chk (
  .vco_clk (vco_clk),
  .src_clk (src_clk),
  .rst_n   (rst_n),
  .run     (run),
  .byp_q   (byp_q),
  .oe_a    (oe_a),
  .oe_bc   (oe_bc),
  .oe_ref  (oe_ref),
  .en_a    (en_a),
  .en_bc   (en_bc),
  .en_ref  (en_ref),
  .clk_a   (clk_a),
  .clk_b   (clk_b),
  .clk_c   (clk_c),
  .ref_out (ref_out),
  .ratio_a (ratio_a),
  .ratio_b (ratio_b),
  .ratio_c (ratio_c)
);

// File: tb/tb_mbank_clkdiv.sv
module tb_mbank_clkdiv;
  localparam int CLK_PERIOD = 10;
  localparam int XT_PERIOD  = 40;
  localparam int EXT_PERIOD = 70;
  localparam int NA = 2;
  localparam int NB = 7;
  localparam int NR = 2;
  localparam longint WD_TIME = 150000 * CLK_PERIOD;

  localparam int TBL_A  [4] = '{20, 16, 10, 8};
  localparam int TBL_BC [8] = '{60, 40, 30, 20, 16, 15, 12, 10};

  logic vco_clk = 1'b0, xtal_clk = 1'b0, ext_ref_clk = 1'b0;
  logic rst_n, ref_pick, bypass, oe_a, oe_bc, oe_ref;
  logic [1:0] sel_a;
  logic [2:0] sel_b, sel_c;
  logic [NA-1:0] clk_a;
  logic [NB-1:0] clk_b;
  logic clk_c;
  logic [NR-1:0] ref_out;
  logic en_a, en_bc, en_ref;

  int checks = 0;
  int errors = 0;
  int probe  = 0;
  logic mon;

  typedef struct {
    int    probe;
    int    hi;
    int    lo;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  mbank_clkdiv #(.NUM_A(NA), .NUM_B(NB), .NUM_REF(NR)) dut (
    .vco_clk(vco_clk), .xtal_clk(xtal_clk), .ext_ref_clk(ext_ref_clk),
    .rst_n(rst_n), .ref_pick(ref_pick), .bypass(bypass),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .oe_a(oe_a), .oe_bc(oe_bc), .oe_ref(oe_ref),
    .clk_a(clk_a), .clk_b(clk_b), .clk_c(clk_c), .ref_out(ref_out),
    .en_a(en_a), .en_bc(en_bc), .en_ref(en_ref)
  );

  initial forever #(CLK_PERIOD/2) vco_clk = ~vco_clk;
  initial forever #(XT_PERIOD/2) xtal_clk = ~xtal_clk;
  initial forever #(EXT_PERIOD/2) ext_ref_clk = ~ext_ref_clk;

  always_comb begin
    case (probe)
      0:       mon = clk_a[0];
      1:       mon = clk_a[NA-1];
      2:       mon = clk_b[0];
      3:       mon = clk_b[NB-1];
      4:       mon = clk_c;
      5:       mon = ref_out[0];
      6:       mon = ref_out[NR-1];
      default: mon = 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sync_drive();
    @(posedge vco_clk);
    #1;
  endtask

  task automatic apply_reset();
    sync_drive();
    rst_n = 1'b0;
    #(4*EXT_PERIOD);
    sync_drive();
    rst_n = 1'b1;
    #(6*EXT_PERIOD);
  endtask

  // driver side: expected pulse timing for one probe
  task automatic push_ratio(input int pr, input int n, input int period, input string tag);
    exp_t e;
    e.probe = pr;
    e.hi = n * period / 2;
    e.lo = n * period / 2;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor side: pop and time the second full pulse
  task automatic drain();
    while (sb_q.size() > 0) begin
      exp_t e;
      longint t0, t1, t2;
      e = sb_q.pop_front();
      probe = e.probe;
      #1;
      @(posedge mon);
      @(posedge mon);
      t0 = $time;
      @(negedge mon);
      t1 = $time;
      @(posedge mon);
      t2 = $time;
      chk((t1 - t0) == e.hi, {e.tag, " high time"}, t1 - t0, e.hi);
      chk((t2 - t1) == e.lo, {e.tag, " low time"}, t2 - t1, e.lo);
    end
  endtask

  initial begin
    #(WD_TIME);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit bad;
    rst_n = 1'b0; ref_pick = 1'b0; bypass = 1'b0;
    sel_a = '0; sel_b = '0; sel_c = '0;
    oe_a = 1'b1; oe_bc = 1'b1; oe_ref = 1'b0;
    #(4*EXT_PERIOD);

    // R4 reset state and R7 default disabled pass-through
    bad = 1'b0;
    repeat (40) begin
      @(negedge vco_clk);
      if (clk_a != '0 || clk_b != '0 || clk_c) bad = 1'b1;
    end
    chk(!bad, "R4 outputs low in reset", {clk_a, clk_b, clk_c}, 0);
    chk(!en_a && !en_bc, "R4 flags low in reset", {en_a, en_bc}, 0);
    chk(ref_out == '0 && !en_ref, "R7 ref default off", {ref_out, en_ref}, 0);

    // R1 R2 R3 R9 every code, C on a different code than B
    for (int k = 0; k < 8; k++) begin
      sync_drive();
      sel_a = 2'(k); sel_b = 3'(k); sel_c = 3'(7 - k);
      apply_reset();
      push_ratio(0, TBL_A[k % 4], CLK_PERIOD, "R1");
      push_ratio(1, TBL_A[k % 4], CLK_PERIOD, "R1");
      push_ratio(2, TBL_BC[k], CLK_PERIOD, (TBL_BC[k] == 15) ? "R9" : "R2");
      push_ratio(3, TBL_BC[k], CLK_PERIOD, "R2");
      push_ratio(4, TBL_BC[7-k], CLK_PERIOD, (TBL_BC[7-k] == 15) ? "R9" : "R3");
      drain();
    end

    // R11 bank outputs identical at all sampled instants
    bad = 1'b0;
    repeat (300) begin
      @(negedge vco_clk);
      if ((clk_b != '0 && clk_b != '1) || (clk_a != '0 && clk_a != '1)) bad = 1'b1;
      #2;
      if ((clk_b != '0 && clk_b != '1) || (clk_a != '0 && clk_a != '1)) bad = 1'b1;
    end
    chk(!bad, "R11 bank outputs aligned", clk_b, 0);

    // R10 and R5: changes while running are ignored (sel_a 3, sel_b 7 active)
    sync_drive();
    sel_a = 2'd0;
    bypass = 1'b1;
    push_ratio(0, TBL_A[3], CLK_PERIOD, "R10");
    push_ratio(2, TBL_BC[7], CLK_PERIOD, "R5");
    drain();

    // R5 R10 R6: after reset, bypass from crystal and new bank A ratio
    apply_reset();
    push_ratio(0, TBL_A[0], XT_PERIOD, "R10");
    push_ratio(2, TBL_BC[7], XT_PERIOD, "R5");
    drain();

    // R6 R9: bypass from external reference with divide by 15
    sync_drive();
    ref_pick = 1'b1; sel_b = 3'd5;
    apply_reset();
    push_ratio(2, TBL_BC[5], EXT_PERIOD, "R6");
    push_ratio(4, TBL_BC[0], EXT_PERIOD, "R6");
    drain();

    // back to the fast source
    sync_drive();
    bypass = 1'b0; ref_pick = 1'b0;
    apply_reset();
    push_ratio(0, TBL_A[0], CLK_PERIOD, "R5");
    drain();

    // R8 bank A disabled, bank B running
    sync_drive();
    oe_a = 1'b0;
    bad = 1'b0;
    repeat (100) begin
      @(negedge vco_clk);
      if (clk_a != '0) bad = 1'b1;
    end
    chk(!bad && !en_a, "R8 bank A off", {clk_a, en_a}, 0);
    push_ratio(2, TBL_BC[5], CLK_PERIOD, "R8");
    drain();

    // R8 banks B and C disabled, bank A running
    sync_drive();
    oe_a = 1'b1; oe_bc = 1'b0;
    bad = 1'b0;
    repeat (100) begin
      @(negedge vco_clk);
      if (clk_b != '0 || clk_c) bad = 1'b1;
    end
    chk(!bad && !en_bc, "R8 bank BC off", {clk_b, clk_c, en_bc}, 0);
    chk(en_a, "R8 bank A flag on", en_a, 1);
    push_ratio(0, TBL_A[0], CLK_PERIOD, "R8");
    drain();
    sync_drive();
    oe_bc = 1'b1;

    // R6 R7 reference pass-through
    sync_drive();
    oe_ref = 1'b1;
    #1;
    chk(en_ref, "R7 ref flag on", en_ref, 1);
    push_ratio(5, 1, XT_PERIOD, "R6");
    drain();
    sync_drive();
    ref_pick = 1'b1;
    push_ratio(6, 1, EXT_PERIOD, "R6");
    drain();
    sync_drive();
    oe_ref = 1'b0;
    bad = 1'b0;
    repeat (100) begin
      @(negedge vco_clk);
      if (ref_out != '0) bad = 1'b1;
    end
    chk(!bad && !en_ref, "R7 ref off", {ref_out, en_ref}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule